// File: doc/BRIEF.md
# RF Synthesizer Serial Programming Latches

This block is the programming front end for the RF half of a dual frequency synthesizer. A host drives three wires: serial clock, serial data and load. The block samples them on its own system clock and shifts the data bits into a 24-bit word. On a rising edge of load, the two lowest bits of that word pick a destination. Code 10 fills the reference latch and code 11 fills the feedback-divider latch. Codes 00 and 01 belong to the IF half, which lives elsewhere, so the RF latches keep their values.

The latch outputs feed the divider counters, the phase detector and the charge pump that sit next to this block. The feedback latch has a fastlock bit. While it is set, the block drives the charge-pump current code to its maximum and asserts a switch output for the loop filter. The same single write that loads a new divide value can therefore enter or leave fastlock.

Top module: `rfsyn_top`

## Requirements
- R1: After reset every latch field reads zero, except that `cp_tristate` reads 1. `fastlock` reads 0, so `cp_code` reads 0.
- R2: On each rising edge of `ser_clk`, the `ser_data` bit is shifted into the word MSB first. Only the 24 most recent bits are kept, and earlier bits have no effect.
- R3: On a load with word[1:0] = 10, the reference latch takes its fields from the word: `ref_div` = word[15:2], `pd_polarity` = word[16], `cp_tristate` = word[17], stored current code = word[20:18], `power_down` = word[21].
- R4: On a load with word[1:0] = 11, the feedback latch takes its fields from the word: `a_count` = word[7:2], `b_count` = word[19:8], `prescaler` = word[21:20], fastlock bit = word[22].
- R5: A load with word[1:0] = 00 or 01 leaves every output unchanged.
- R6: Writing one RF latch leaves every field of the other RF latch unchanged.
- R7: While the fastlock bit is 1, `cp_code` reads 3'b111 and `fastlock` reads 1, whatever current code is stored. Writing the feedback latch with the fastlock bit at 0 restores the stored code and drops `fastlock`.
- R8: Serial clock edges and data bits alone do not change any output. Outputs change only on a load.
- R9: The new values appear after the second system clock edge that follows the rising edge of `ser_load`, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial wires |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_load | input | 1 | Load strobe; its rising edge transfers the word |
| ref_div | output | 14 | Reference divide value |
| a_count | output | 6 | Swallow counter value |
| b_count | output | 12 | Programmable counter value |
| prescaler | output | 2 | Prescaler select |
| pd_polarity | output | 1 | Phase detector polarity (1 = positive VCO slope) |
| cp_tristate | output | 1 | Charge pump in high impedance when 1 |
| cp_code | output | 3 | Effective charge-pump current code |
| power_down | output | 1 | RF section power-down |
| fastlock | output | 1 | Fastlock active; drives the loop-filter switch |

## Verification
A wrong shift register state shows up on the next load as fields that are moved or bit-reversed. A broken edge detector shows up as outputs that change while bits are still being shifted, or that do not change two clocks after load. A bad destination decode corrupts the latch that was not addressed, and that error stays visible on the outputs until that latch is written again. A bad fastlock override shows up at once on `cp_code` and `fastlock` as soon as the feedback latch has been written.

// File: rtl/rfsyn_pkg.sv
package rfsyn_pkg;
    localparam int WORD_W = 24;
    localparam int CTRL_W = 2;
    localparam int RDIV_W = 14;
    localparam int A_W    = 6;
    localparam int B_W    = 12;
    localparam int PS_W   = 2;
    localparam int CPC_W  = 3;

    // reference latch field positions
    localparam int RDIV_LSB = CTRL_W;
    localparam int POL_BIT  = RDIV_LSB + RDIV_W;
    localparam int TRI_BIT  = POL_BIT + 1;
    localparam int CPC_LSB  = TRI_BIT + 1;
    localparam int PWD_BIT  = CPC_LSB + CPC_W;

    // feedback latch field positions
    localparam int A_LSB  = CTRL_W;
    localparam int B_LSB  = A_LSB + A_W;
    localparam int PS_LSB = B_LSB + B_W;
    localparam int FL_BIT = PS_LSB + PS_W;

    typedef enum logic [CTRL_W-1:0] {
        SEL_IF_REF = 2'b00,
        SEL_IF_FB  = 2'b01,
        SEL_RF_REF = 2'b10,
        SEL_RF_FB  = 2'b11
    } sel_e;

    typedef struct packed {
        logic             pwr_dn;
        logic [CPC_W-1:0] cp_cur;
        logic             tri_st;
        logic             pol;
        logic [RDIV_W-1:0] rdiv;
    } ref_latch_t;

    typedef struct packed {
        logic             fl;
        logic [PS_W-1:0]  presc;
        logic [B_W-1:0]   b;
        logic [A_W-1:0]   a;
    } fb_latch_t;
endpackage

// File: rtl/rfsyn_edge.sv
module rfsyn_edge #(
    parameter int N_STB = 2,
    parameter int AUX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STB-1:0] stb_in,
    input  logic [AUX_W-1:0] aux_in,
    output logic [N_STB-1:0] stb_rise,
    output logic [AUX_W-1:0] aux_q
);
    typedef struct packed {
        logic [N_STB-1:0] smp;
        logic [N_STB-1:0] prv;
        logic [AUX_W-1:0] aux;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.prv = st_q.smp;
        st_d.smp = stb_in;
        st_d.aux = aux_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N_STB; g++) begin : g_rise
        assign stb_rise[g] = st_q.smp[g] & ~st_q.prv[g];
    end

    assign aux_q = st_q.aux;
endmodule

// File: rtl/rfsyn_shift.sv
module rfsyn_shift #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word_q
);
    logic [W-1:0] word_d, sr_q;

    always_comb begin
        word_d = sr_q;
        if (shift_en) word_d = {sr_q[W-2:0], bit_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= word_d;
    end

    assign word_q = sr_q;
endmodule

// File: rtl/rfsyn_latch.sv
module rfsyn_latch
    import rfsyn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [WORD_W-1:0] word,
    output ref_latch_t        ref_q,
    output fb_latch_t         fb_q
);
    typedef struct packed {
        ref_latch_t r;
        fb_latch_t  f;
    } st_t;

    st_t  st_d, st_q;
    sel_e sel;

    assign sel = sel_e'(word[CTRL_W-1:0]);

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            unique case (sel)
                SEL_RF_REF: begin
                    st_d.r.rdiv   = word[RDIV_LSB +: RDIV_W];
                    st_d.r.pol    = word[POL_BIT];
                    st_d.r.tri_st = word[TRI_BIT];
                    st_d.r.cp_cur = word[CPC_LSB +: CPC_W];
                    st_d.r.pwr_dn = word[PWD_BIT];
                end
                SEL_RF_FB: begin
                    st_d.f.a     = word[A_LSB +: A_W];
                    st_d.f.b     = word[B_LSB +: B_W];
                    st_d.f.presc = word[PS_LSB +: PS_W];
                    st_d.f.fl    = word[FL_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.r.tri_st <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ref_q = st_q.r;
    assign fb_q  = st_q.f;
endmodule

// File: rtl/rfsyn_top.sv
module rfsyn_top
    import rfsyn_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_load,
    output logic [RDIV_W-1:0] ref_div,
    output logic [A_W-1:0]    a_count,
    output logic [B_W-1:0]    b_count,
    output logic [PS_W-1:0]   prescaler,
    output logic              pd_polarity,
    output logic              cp_tristate,
    output logic [CPC_W-1:0]  cp_code,
    output logic              power_down,
    output logic              fastlock
);
    logic [1:0]        rise;
    logic              data_s;
    logic              load_stb;
    logic [WORD_W-1:0] sr_word;
    ref_latch_t        ref_l;
    fb_latch_t         fb_l;

    rfsyn_edge #(.N_STB(2), .AUX_W(1)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb_in  ({ser_load, ser_clk}),
        .aux_in  (ser_data),
        .stb_rise(rise),
        .aux_q   (data_s)
    );

    assign load_stb = rise[1];

    rfsyn_shift #(.W(WORD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(rise[0]),
        .bit_in  (data_s),
        .word_q  (sr_word)
    );

    rfsyn_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(load_stb),
        .word   (sr_word),
        .ref_q  (ref_l),
        .fb_q   (fb_l)
    );

    always_comb begin
        ref_div     = ref_l.rdiv;
        pd_polarity = ref_l.pol;
        cp_tristate = ref_l.tri_st;
        power_down  = ref_l.pwr_dn;
        a_count     = fb_l.a;
        b_count     = fb_l.b;
        prescaler   = fb_l.presc;
        fastlock    = fb_l.fl;
        cp_code     = fb_l.fl ? {CPC_W{1'b1}} : ref_l.cp_cur;
    end
endmodule

// File: rtl/rfsyn_chk.sv
module rfsyn_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_stb,
    input logic [23:0] word,
    input logic [13:0] ref_div,
    input logic [5:0]  a_count,
    input logic [11:0] b_count,
    input logic [1:0]  prescaler,
    input logic        pd_polarity,
    input logic        cp_tristate,
    input logic [2:0]  cp_code,
    input logic        power_down,
    input logic        fastlock
);
    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    // R8
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(load_stb) |->
        $stable({ref_div, a_count, b_count, prescaler, pd_polarity,
                 cp_tristate, cp_code, power_down, fastlock}));

    // R5
    if_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(load_stb) && !$past(word[1]) |->
        $stable({ref_div, a_count, b_count, prescaler, pd_polarity,
                 cp_tristate, cp_code, power_down, fastlock}));

    // R3
    ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(load_stb) && ($past(word[1:0]) == 2'b10) |->
        (ref_div == $past(word[15:2])) && (pd_polarity == $past(word[16])) &&
        $stable({a_count, b_count, prescaler, fastlock}));

    // R4
    fb_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(load_stb) && ($past(word[1:0]) == 2'b11) |->
        (a_count == $past(word[7:2])) && (b_count == $past(word[19:8])) &&
        $stable({ref_div, pd_polarity, cp_tristate, power_down}));

    // R7
    fl_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $rose(fastlock) |-> $past(load_stb) && $past(word[22]));
endmodule

bind rfsyn_top rfsyn_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_stb   (load_stb),
    .word       (sr_word),
    .ref_div    (ref_div),
    .a_count    (a_count),
    .b_count    (b_count),
    .prescaler  (prescaler),
    .pd_polarity(pd_polarity),
    .cp_tristate(cp_tristate),
    .cp_code    (cp_code),
    .power_down (power_down),
    .fastlock   (fastlock)
);

// File: tb/tb_rfsyn_top.sv
module tb_rfsyn_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_load = 1'b0;
    logic [13:0] ref_div;
    logic [5:0]  a_count;
    logic [11:0] b_count;
    logic [1:0]  prescaler;
    logic        pd_polarity, cp_tristate, power_down, fastlock;
    logic [2:0]  cp_code;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // model
    logic [13:0] m_rdiv = '0;
    logic        m_pol = 1'b0, m_tri = 1'b1, m_pwd = 1'b0, m_fl = 1'b0;
    logic [2:0]  m_cpc = '0;
    logic [5:0]  m_a = '0;
    logic [11:0] m_b = '0;
    logic [1:0]  m_ps = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rfsyn_top dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .ref_div(ref_div), .a_count(a_count),
        .b_count(b_count), .prescaler(prescaler), .pd_polarity(pd_polarity),
        .cp_tristate(cp_tristate), .cp_code(cp_code), .power_down(power_down),
        .fastlock(fastlock)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "ref_div", 32'(ref_div), 32'(m_rdiv));
        chk(req, "pd_polarity", 32'(pd_polarity), 32'(m_pol));
        chk(req, "cp_tristate", 32'(cp_tristate), 32'(m_tri));
        chk(req, "power_down", 32'(power_down), 32'(m_pwd));
        chk(req, "a_count", 32'(a_count), 32'(m_a));
        chk(req, "b_count", 32'(b_count), 32'(m_b));
        chk(req, "prescaler", 32'(prescaler), 32'(m_ps));
        chk(req, "fastlock", 32'(fastlock), 32'(m_fl));
        chk(req, "cp_code", 32'(cp_code), m_fl ? 32'd7 : 32'(m_cpc));
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk) ser_data = v[i];
            @(negedge clk) ser_clk = 1'b1;
            @(negedge clk) ser_clk = 1'b0;
        end
    endtask

    task automatic model_load(input logic [23:0] w);
        if (w[1:0] == 2'b10) begin
            m_rdiv = w[15:2]; m_pol = w[16]; m_tri = w[17];
            m_cpc = w[20:18]; m_pwd = w[21];
        end else if (w[1:0] == 2'b11) begin
            m_a = w[7:2]; m_b = w[19:8]; m_ps = w[21:20]; m_fl = w[22];
        end
    endtask

    task automatic pulse_load();
        @(negedge clk) ser_load = 1'b1;
        repeat (2) @(negedge clk);
        ser_load = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic write_word(input logic [23:0] w, input string req);
        send_bits(24, {8'h0, w});
        pulse_load();
        model_load(w);
        chk_all(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++; tests++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
                $display("[TB] %0d tests run, %0d failed", tests, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [23:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1");

        // R3 / R6: reference latch sweep over all current codes and flag mixes
        for (int c = 0; c < 8; c++) begin
            w = {2'b00, 1'(c & 1), 3'(c), 1'(c >> 1), 1'(c >> 2),
                 14'(16'h1357 * (c + 1)), 2'b10};
            write_word(w, "R3_R6");
        end

        // R4 / R6: feedback latch sweep
        for (int k = 0; k < 8; k++) begin
            w = {1'b0, 1'b0, 2'(k), 12'(12'h9A5 + k * 12'h111), 6'(k * 7 + 3), 2'b11};
            write_word(w, "R4_R6");
        end

        // R7: fastlock overrides every stored current code, then releases
        for (int c = 0; c < 8; c++) begin
            w = {2'b00, 1'b0, 3'(c), 1'b0, 1'b1, 14'(c + 100), 2'b10};
            write_word(w, "R7_ref");
            w = {1'b0, 1'b1, 2'b10, 12'(c + 40), 6'(c), 2'b11};
            write_word(w, "R7_on");
            chk("R7", "fl switch", 32'(fastlock), 32'd1);
            w = {1'b0, 1'b0, 2'b01, 12'(c + 41), 6'(c + 1), 2'b11};
            write_word(w, "R7_off");
            chk("R7", "restored cp", 32'(cp_code), 32'(c));
        end
        // R7: fastlock persists across a reference write
        write_word({1'b0, 1'b1, 2'b11, 12'hABC, 6'h2A, 2'b11}, "R7_on2");
        write_word({2'b00, 1'b1, 3'd2, 1'b0, 1'b0, 14'h0041, 2'b10}, "R7_hold");

        // R5: IF codes leave RF latches unchanged
        write_word({22'h3FFFFF, 2'b00}, "R5");
        write_word({22'h3FFFFF, 2'b01}, "R5");
        write_word({22'h000000, 2'b01}, "R5");

        // R2: extra leading bits are dropped, order is MSB first
        send_bits(6, 32'h3F);
        send_bits(24, {8'h0, 2'b00, 1'b1, 3'd5, 1'b1, 1'b0, 14'h2C81, 2'b10});
        pulse_load();
        model_load({2'b00, 1'b1, 3'd5, 1'b1, 1'b0, 14'h2C81, 2'b10});
        chk_all("R2");
        chk("R2", "ref_div order", 32'(ref_div), 32'h2C81);

        // R8: shifting without load changes nothing; then load alone applies it
        w = {1'b0, 1'b0, 2'b01, 12'h123, 6'h15, 2'b11};
        send_bits(24, {8'h0, w});
        repeat (3) @(negedge clk);
        chk_all("R8");

        // R9: latency of two system clock edges
        @(negedge clk) ser_load = 1'b1;
        @(negedge clk);
        chk_all("R9_early");
        @(negedge clk);
        model_load(w);
        chk_all("R9");
        ser_load = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R9_after");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule